// File: doc/BRIEF.md
# Transmit Collision and Carrier Guard

This block sits next to the driver of a shared two-wire line and decides, cycle by cycle, whether the driver may stay enabled. During a telegram it reads back the level on the line, brings it into the clock domain, and compares it with the level the station itself drove. The driven level is delayed by the same number of cycles as the read-back path so that the two line up. A run of disagreements outside a short blanking interval means another station is also driving. The guard then drops the driver enable and records the event in a sticky collision flag.

The guard is armed when the controller writes the activate control bit from 0 to 1. In the armed state it waits for the telegram request. If the station is configured as transmit master and the receiver reports carrier on the selected channel before the telegram has begun, the line is already in use. The guard then refuses to start and raises the same flag. When a telegram ends cleanly the guard disarms itself, so a second telegram needs a fresh activate edge. Line coding and retry back-off belong to other blocks.

The controller uses the state machine as follows:
- It has four states: IDLE (not armed), ARMED (waiting to start), SEND (driver on, comparing) and HALT (driver off after a collision or a blocked start).
- IDLE→ARMED and HALT→ARMED are taken on an activate rising edge.
- ARMED→HALT is taken on carrier seen while in master mode.
- ARMED→SEND is taken on the telegram request.
- SEND→HALT is taken on a confirmed mismatch.
- SEND→IDLE is taken when the request falls.

Top module: `txline_guard`

## Requirements
- R1: After reset `drv_en`, `armed` and `coll_flag` are all 0.
- R2: A 0→1 change of `cfg_activate` while in IDLE or HALT makes `armed` 1 on the next cycle; from ARMED, a high `tx_req` sets `drv_en` one cycle later.
- R3: While driving, once the synchronized read-back disagrees with the equally delayed driven level on MIS_N (default 2) consecutive compared cycles, `drv_en` drops and `coll_flag` is set on the following cycle.
- R4: A read-back disagreement lasting a single sample does not end the telegram or set the flag.
- R5: No comparison is made for BLANK+SYNC_STAGES (default 3+2) cycles after each change of `tx_data` and after the start of driving; a disagreement that outlasts this window is still caught.
- R6: In ARMED with `cfg_master`=1, carrier on the channel picked by `chan_sel` (0 selects `carrier[0]`, 1 selects `carrier[1]`) sets `coll_flag` and moves to HALT; the driver is never enabled, even when `tx_req` is high in the same cycle.
- R7: Carrier on the channel not selected, or any carrier while `cfg_master`=0, does not block the start.
- R8: When `tx_req` falls during driving without a collision, `drv_en` and `armed` drop. A later `tx_req` does nothing until a new 0→1 of `cfg_activate`.
- R9: `coll_flag` stays set, and the driver off, until a 0→1 of `cfg_activate`, which clears it; a level held at 1 does not clear it.
- R10: While not armed, carrier and read-back disagreement have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_data | input | 1 | Level to be driven on the line |
| tx_req | input | 1 | Telegram request, high for the telegram length |
| line_rb | input | 1 | Asynchronous read-back of the line level |
| carrier | input | N_CH | Carrier detect per receive channel |
| chan_sel | input | CH_W | Channel whose carrier is checked before start |
| cfg_master | input | 1 | Control bit: station transmits as master |
| cfg_activate | input | 1 | Control bit: arm for one telegram on 0→1 |
| drv_en | output | 1 | Line driver enable |
| armed | output | 1 | Guard is armed or driving |
| coll_flag | output | 1 | Sticky collision status |

## Verification
The bench builds the guard with its defaults: two synchronizer stages, a blanking of three cycles and a two-sample mismatch filter, over two carrier channels. With these small values, one-cycle glitches and disagreements that end one cycle before or well after the five-cycle window can be placed exactly on the boundaries of R4 and R5. Both values of the channel select can also be tried against carrier on either channel. A behavioural model, built from sample queues, follows every cycle and is compared with all three outputs on each clock.

// File: rtl/txg_pkg.sv
package txg_pkg;

    typedef enum logic [1:0] {
        G_IDLE  = 2'd0,
        G_ARMED = 2'd1,
        G_SEND  = 2'd2,
        G_HALT  = 2'd3
    } guard_st_t;

endpackage

// File: rtl/txg_sync.sv
module txg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/txg_cmp.sv
module txg_cmp #(
    parameter int SYNC_STAGES = 2,
    parameter int BLANK       = 3,
    parameter int MIS_N       = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_bit,
    input  logic rb_sync,
    input  logic in_send,
    output logic collide
);
    localparam int LOAD = BLANK + SYNC_STAGES;
    localparam int CW   = $clog2(LOAD + 1);
    localparam int RW   = (MIS_N > 1) ? $clog2(MIS_N + 1) : 1;

    logic [SYNC_STAGES-1:0] tx_dly;
    logic                   tx_prev;
    logic [CW-1:0]          blank_cnt;
    logic [RW-1:0]          run;
    logic                   tx_edge, cmp_en, mis;

    generate
        if (SYNC_STAGES == 1) begin : g_d1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) tx_dly <= '0;
                else        tx_dly <= tx_bit;
            end
        end else begin : g_dn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) tx_dly <= '0;
                else        tx_dly <= {tx_dly[SYNC_STAGES-2:0], tx_bit};
            end
        end
    endgenerate

    assign tx_edge = (tx_bit != tx_prev);
    assign cmp_en  = in_send && (blank_cnt == '0);
    assign mis     = cmp_en && (rb_sync != tx_dly[SYNC_STAGES-1]);
    assign collide = mis && (run == RW'(MIS_N - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_prev   <= 1'b0;
            blank_cnt <= CW'(LOAD);
            run       <= '0;
        end else begin
            tx_prev <= tx_bit;
            if (!in_send || tx_edge) blank_cnt <= CW'(LOAD);
            else if (blank_cnt != '0) blank_cnt <= blank_cnt - 1'b1;
            if (!mis) run <= '0;
            else if (run != RW'(MIS_N - 1)) run <= run + 1'b1;
        end
    end

    // R5: an edge of the driven level opens a window with no comparison
    a_r5_edge_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        (in_send && tx_edge) |=> !collide);

    generate
        if (MIS_N > 1) begin : g_filt
            // R4: a confirmed mismatch needs an earlier mismatching sample
            a_r4_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
                collide |-> $past(mis));
        end
    endgenerate
endmodule

// File: rtl/txg_fsm.sv
module txg_fsm
    import txg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic act_rise,
    input  logic tx_req,
    input  logic master,
    input  logic car_hit,
    input  logic collide,
    output logic drv_en,
    output logic armed,
    output logic coll_flag
);
    guard_st_t state, state_nx;
    logic      flag_nx;

    always_comb begin
        state_nx = state;
        flag_nx  = coll_flag;
        unique case (state)
            G_IDLE: begin
                if (act_rise) state_nx = G_ARMED;
            end
            G_ARMED: begin
                if (master && car_hit) begin
                    state_nx = G_HALT;
                    flag_nx  = 1'b1;
                end else if (tx_req) begin
                    state_nx = G_SEND;
                end
            end
            G_SEND: begin
                if (collide) begin
                    state_nx = G_HALT;
                    flag_nx  = 1'b1;
                end else if (!tx_req) begin
                    state_nx = G_IDLE;
                end
            end
            G_HALT: begin
                if (act_rise) begin
                    state_nx = G_ARMED;
                    flag_nx  = 1'b0;
                end
            end
            default: state_nx = G_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= G_IDLE;
            coll_flag <= 1'b0;
        end else begin
            state     <= state_nx;
            coll_flag <= flag_nx;
        end
    end

    always_comb begin
        drv_en = (state == G_SEND);
        armed  = (state == G_ARMED) || (state == G_SEND);
    end

    // R3: a confirmed mismatch releases the driver and latches the flag
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> (!drv_en && coll_flag));
    // R6: carrier before start in master mode blocks the driver
    a_r6_block_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == G_ARMED && master && car_hit) |=> (state == G_HALT && !drv_en));
    // R8: a clean end of telegram disarms
    a_r8_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == G_SEND && !tx_req && !collide) |=> (!armed && !coll_flag));
    // R9: the flag holds until an activate edge
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_flag && !act_rise) |=> coll_flag);
    // R9: the driver is never on while the flag is set
    a_r9_no_drive_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> !coll_flag);
endmodule

// File: rtl/txline_guard.sv
module txline_guard #(
    parameter int  SYNC_STAGES = 2,
    parameter int  BLANK       = 3,
    parameter int  MIS_N       = 2,
    parameter int  N_CH        = 2,
    localparam int CH_W        = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_data,
    input  logic            tx_req,
    input  logic            line_rb,
    input  logic [N_CH-1:0] carrier,
    input  logic [CH_W-1:0] chan_sel,
    input  logic            cfg_master,
    input  logic            cfg_activate,
    output logic            drv_en,
    output logic            armed,
    output logic            coll_flag
);
    logic act_q, act_rise, rb_sync, collide, car_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= cfg_activate;
    end
    assign act_rise = cfg_activate && !act_q;
    assign car_hit  = carrier[chan_sel];

    txg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(line_rb), .q(rb_sync)
    );

    txg_cmp #(.SYNC_STAGES(SYNC_STAGES), .BLANK(BLANK), .MIS_N(MIS_N)) u_cmp (
        .clk(clk), .rst_n(rst_n), .tx_bit(tx_data), .rb_sync(rb_sync),
        .in_send(drv_en), .collide(collide)
    );

    txg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .act_rise(act_rise), .tx_req(tx_req),
        .master(cfg_master), .car_hit(car_hit), .collide(collide),
        .drv_en(drv_en), .armed(armed), .coll_flag(coll_flag)
    );

    // R10: the flag cannot rise while the guard is not armed
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !coll_flag) |=> !coll_flag);
endmodule

// File: tb/txline_guard_test.sv
module txline_guard_test;
    localparam int SYNC  = 2;
    localparam int BLANK = 3;
    localparam int MISN  = 2;
    localparam int LOADV = BLANK + SYNC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_data = 1'b0, tx_req = 1'b0;
    logic [1:0] carrier = 2'b00;
    logic chan_sel = 1'b0, cfg_master = 1'b0, cfg_activate = 1'b0;
    logic ext_on = 1'b0, ext_lvl = 1'b0, glitch = 1'b0;
    logic line_rb;
    logic drv_en, armed, coll_flag;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    assign line_rb = ext_on ? ext_lvl : (tx_data ^ glitch);

    always #2.5 clk = ~clk;

    txline_guard uut (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_req(tx_req),
        .line_rb(line_rb), .carrier(carrier), .chan_sel(chan_sel),
        .cfg_master(cfg_master), .cfg_activate(cfg_activate),
        .drv_en(drv_en), .armed(armed), .coll_flag(coll_flag)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference: 0 idle, 1 armed, 2 driving, 3 halted
    int m_st, m_blank, m_run;
    bit m_flag, m_act_prev, m_tx_prev;
    bit rbq[$], txq[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_flag = 0; m_act_prev = 0; m_tx_prev = 0;
            m_blank = LOADV; m_run = 0;
            rbq = {}; txq = {};
            for (int i = 0; i < SYNC; i++) begin rbq.push_back(0); txq.push_back(0); end
        end else begin
            bit rb_old, tx_old, cmpv, hit, rise;
            int nst;
            rb_old = rbq[SYNC-1];
            tx_old = txq[SYNC-1];
            cmpv = (m_st == 2) && (m_blank == 0) && (rb_old != tx_old);
            hit  = cmpv && (m_run + 1 >= MISN);
            rise = cfg_activate && !m_act_prev;
            nst = m_st;
            case (m_st)
                0: if (rise) nst = 1;
                1: if (cfg_master && carrier[chan_sel]) begin nst = 3; m_flag = 1; end
                   else if (tx_req) nst = 2;
                2: if (hit) begin nst = 3; m_flag = 1; end
                   else if (!tx_req) nst = 0;
                3: if (rise) begin nst = 1; m_flag = 0; end
                default: nst = 0;
            endcase
            if (m_st != 2 || tx_data != m_tx_prev) m_blank = LOADV;
            else if (m_blank > 0) m_blank--;
            m_run = cmpv ? ((m_run + 1 >= MISN) ? MISN - 1 : m_run + 1) : 0;
            m_st = nst;
            m_tx_prev = tx_data;
            m_act_prev = cfg_activate;
            rbq.push_front(line_rb); void'(rbq.pop_back());
            txq.push_front(tx_data); void'(txq.pop_back());
        end
    end

    // every-clock comparison with the model
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            chk("R2/R3 drv_en vs model", int'(drv_en), int'(m_st == 2));
            chk("R8 armed vs model", int'(armed), int'(m_st == 1 || m_st == 2));
            chk("R9 coll_flag vs model", int'(coll_flag), int'(m_flag));
        end
        if (cyc > 20000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic arm();
        cfg_activate = 1'b0; tick(1);
        cfg_activate = 1'b1; tick(1);
    endtask

    task automatic send_pattern(int n, int seed);
        for (int i = 0; i < n; i++) begin
            tx_data = ((i + seed) % 3 == 0) ^ ((i / 4) % 2 == 1);
            tick(1);
        end
    endtask

    initial begin
        tick(3);
        chk("R1 reset drv_en", int'(drv_en), 0);
        chk("R1 reset armed", int'(armed), 0);
        chk("R1 reset coll_flag", int'(coll_flag), 0);
        rst_n = 1'b1;
        tick(2);

        // R10: activity while idle is ignored
        carrier = 2'b11; cfg_master = 1'b1; ext_on = 1'b1; ext_lvl = 1'b1;
        tick(8);
        chk("R10 idle flag", int'(coll_flag), 0);
        chk("R10 idle drv", int'(drv_en), 0);
        carrier = 2'b00; ext_on = 1'b0; cfg_master = 1'b0;

        // R2, R8: clean telegram with echoed line
        arm();
        chk("R2 armed after edge", int'(armed), 1);
        tx_req = 1'b1; tick(1);
        chk("R2 driver on", int'(drv_en), 1);
        send_pattern(30, 0);
        chk("R2 still driving", int'(drv_en), 1);
        tx_req = 1'b0; tick(1);
        chk("R8 driver off at end", int'(drv_en), 0);
        chk("R8 disarmed", int'(armed), 0);
        tx_req = 1'b1; tick(6);
        chk("R8 no restart without edge", int'(drv_en), 0);
        tx_req = 1'b0; tick(1);

        // R4: single-sample glitch
        arm(); tx_req = 1'b1; tx_data = 1'b0; tick(10);
        glitch = 1'b1; tick(1); glitch = 1'b0; tick(6);
        chk("R4 glitch ignored drv", int'(drv_en), 1);
        chk("R4 glitch ignored flag", int'(coll_flag), 0);

        // R5: disagreement confined to the blanking window
        tx_data = 1'b1; ext_on = 1'b1; ext_lvl = 1'b0; tick(3);
        ext_on = 1'b0; tick(8);
        chk("R5 inside window drv", int'(drv_en), 1);
        chk("R5 inside window flag", int'(coll_flag), 0);

        // R5, R3: disagreement that outlasts the window
        tx_data = 1'b0; ext_on = 1'b1; ext_lvl = 1'b1; tick(10);
        chk("R5 late mismatch caught", int'(coll_flag), 1);
        chk("R3 driver released", int'(drv_en), 0);
        ext_on = 1'b0;

        // R9: held activate does not clear; tx_req ignored
        tick(5);
        chk("R9 flag sticky", int'(coll_flag), 1);
        chk("R9 no drive while flagged", int'(drv_en), 0);
        tx_req = 1'b0;
        arm();
        chk("R9 cleared by edge", int'(coll_flag), 0);

        // R3: steady opposite level mid telegram
        tx_req = 1'b1; tick(1); send_pattern(12, 1);
        tx_data = 1'b1; tick(8);
        ext_on = 1'b1; ext_lvl = 1'b0; tick(6);
        chk("R3 collision flag", int'(coll_flag), 1);
        chk("R3 drv dropped", int'(drv_en), 0);
        ext_on = 1'b0; tx_req = 1'b0; tick(2);

        // R6: carrier on selected channel in master mode, same cycle as request
        cfg_master = 1'b1; chan_sel = 1'b1;
        arm();
        carrier = 2'b10; tx_req = 1'b1; tick(3);
        chk("R6 start blocked drv", int'(drv_en), 0);
        chk("R6 flag set", int'(coll_flag), 1);
        carrier = 2'b00; tx_req = 1'b0; tick(1);

        // R7: carrier on the other channel
        arm();
        carrier = 2'b01; tx_req = 1'b1; tick(2);
        chk("R7 other channel drv", int'(drv_en), 1);
        chk("R7 other channel flag", int'(coll_flag), 0);
        tx_req = 1'b0; tick(1);

        // R7: master bit clear
        cfg_master = 1'b0; chan_sel = 1'b0;
        arm();
        carrier = 2'b01; tx_req = 1'b1; tick(2);
        chk("R7 not master drv", int'(drv_en), 1);
        send_pattern(10, 2);
        tx_req = 1'b0; carrier = 2'b00; tick(2);
        chk("R8 final idle", int'(armed), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule